// File: doc/BRIEF.md
# Page-Staged Nonvolatile Array Controller

This block fronts a byte-addressed nonvolatile array, modelled as on-chip registers, with a 64-byte staging page. A single command port carries a 12-bit address and one of three operations. A load places one byte into the staging page and leaves the array alone. A read returns one byte straight from the array. A commit writes the staging page into one array page. The address splits into a page field in bits 11:6 and a byte field in bits 5:0, and each operation uses a different part of it.

A commit writes only the bytes that were loaded since the last commit. Every other byte of the target page keeps its old value, so updating part of a page needs no read-modify-write. A per-byte occupancy mask records the loaded bytes and is cleared when the commit completes. A commit takes a parameterised number of cycles. During that time `busy` is high and every command is dropped. A single-cycle `done` pulse marks the end of the commit. A read or commit that names a page at or above the configured page count is rejected with an `err` pulse.

Top module: `eep_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `done`, `err` and `rd_valid` are low and the occupancy mask is empty, so a commit issued before any load changes no array byte.
- R2: A load (`cmd_op` = 2'b01) writes `cmd_wdata` into staging byte `cmd_addr[5:0]`. Bits 11:6 are ignored and the array is not touched. A later load to the same byte replaces the earlier one.
- R3: A read (`cmd_op` = 2'b10) of an in-range page raises `rd_valid` for exactly the next cycle. In that cycle `rd_data` holds the array byte at page `cmd_addr[11:6]`, offset `cmd_addr[5:0]`.
- R4: A commit (`cmd_op` = 2'b11) ignores `cmd_addr[5:0]` and writes into page `cmd_addr[11:6]` only the staged bytes. Every unstaged byte of that page keeps its prior value.
- R5: When a commit completes, the occupancy mask is cleared. A following commit with no new loads leaves its page unchanged.
- R6: After an accepted commit, `busy` is high for exactly PROG_CYCLES cycles. `done` pulses for one cycle as `busy` falls, and from that cycle reads return the new bytes.
- R7: Any command presented while `busy` is high has no effect. This includes a command presented in the last busy cycle, when the commit lands.
- R8: A read or commit whose page field is PAGES or more raises `err` for one cycle. It produces no `rd_valid`, does not start a commit, changes no array byte and keeps the staged bytes and mask.
- R9: The array contents persist across a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 01 load, 10 read, 11 commit, 00 idle |
| cmd_addr | input | 12 | Page field in [11:6], byte field in [5:0] |
| cmd_wdata | input | 8 | Byte to stage for a load |
| busy | output | 1 | Commit in progress; commands are dropped |
| done | output | 1 | One-cycle pulse when a commit completes |
| err | output | 1 | One-cycle pulse for an out-of-range read or commit |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 8 | Byte returned by the last read |

## Verification
Two things can happen at the same clock edge: a commit completes, which writes the array and clears the mask, and a new load arrives. The bench provokes this by timing a load so that it is sampled at the exact edge where the commit lands. The expected outcome is that the load is dropped, so the mask stays clear after the commit. A later commit of another page must then leave that byte unchanged. The reference model in the bench, stepped on every clock, predicts `busy`, `done`, `err`, `rd_valid` and `rd_data` through these edges and around them.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam int ADDR_W     = 12;
  localparam int OFS_W      = 6;
  localparam int PAGE_BYTES = 64;
  localparam int PSEL_W     = ADDR_W - OFS_W;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_LOAD = 2'b01,
    OP_READ = 2'b10,
    OP_PROG = 2'b11
  } eep_op_e;

  typedef logic [PAGE_BYTES-1:0][7:0] page_t;

  function automatic logic [PSEL_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  function automatic logic [OFS_W-1:0] ofs_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction

  function automatic logic page_in_range(input logic [PSEL_W-1:0] p,
                                         input int unsigned pages);
    return 32'(p) < pages;
  endfunction

  // Keep the stored byte unless this position was staged.
  function automatic logic [7:0] merge_byte(input logic [7:0] old_b,
                                            input logic [7:0] new_b,
                                            input logic       sel);
    return sel ? new_b : old_b;
  endfunction

endpackage

// File: rtl/eep_stage.sv
module eep_stage
  import eep_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic [OFS_W-1:0]      load_ofs,
  input  logic [7:0]            load_data,
  input  logic                  clear,
  output page_t                 stage_q,
  output logic [PAGE_BYTES-1:0] mask_q
);

  logic [PAGE_BYTES-1:0] hit;

  generate
    for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_hit
      assign hit[b] = load_en && (load_ofs == OFS_W'(b));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      mask_q  <= '0;
    end else if (clear) begin
      mask_q <= '0;
    end else begin
      for (int b = 0; b < PAGE_BYTES; b++) begin
        if (hit[b]) begin
          stage_q[b] <= load_data;
          mask_q[b]  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/eep_seq.sv
module eep_seq #(
  parameter int PROG_CYCLES = 16,
  parameter int PW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] start_page,
  output logic          busy,
  output logic          commit,
  output logic          done,
  output logic [PW-1:0] tgt_page
);

  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic          active;
  logic [CW-1:0] cnt;

  assign busy   = active;
  assign commit = active && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cnt      <= '0;
      done     <= 1'b0;
      tgt_page <= '0;
    end else begin
      done <= commit;
      if (start) begin
        active   <= 1'b1;
        cnt      <= CW'(PROG_CYCLES - 1);
        tgt_page <= start_page;
      end else if (commit) begin
        active <= 1'b0;
      end else if (active) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/eep_array.sv
module eep_array
  import eep_pkg::*;
#(
  parameter int PAGES = 32,
  parameter int PW    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [PW-1:0]         tgt_page,
  input  page_t                 stage,
  input  logic [PAGE_BYTES-1:0] mask,
  input  logic                  rd_en,
  input  logic [PW-1:0]         rd_page,
  input  logic [OFS_W-1:0]      rd_ofs,
  output logic                  rd_valid,
  output logic [7:0]            rd_data
);

  // Storage is never reset: its contents persist across a reset.
  logic [7:0] mem [PAGES][PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int b = 0; b < PAGE_BYTES; b++) begin
        mem[tgt_page][b] <= merge_byte(mem[tgt_page][b], stage[b], mask[b]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mem[rd_page][rd_ofs];
    end
  end

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int PAGES       = 32,
  parameter int PROG_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [11:0] cmd_addr,
  input  logic [7:0]  cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        rd_valid,
  output logic [7:0]  rd_data
);

  localparam int PW = (PAGES > 1) ? $clog2(PAGES) : 1;

  eep_op_e               op;
  logic                  accept;
  logic [PSEL_W-1:0]     page;
  logic [PW-1:0]         page_idx;
  logic [OFS_W-1:0]      ofs;
  logic                  in_range;
  logic                  load_go;
  logic                  read_go;
  logic                  prog_go;
  logic                  reject_go;
  logic                  busy_w;
  logic                  commit;
  logic                  done_w;
  logic [PW-1:0]         tgt_page;
  page_t                 stage_q;
  logic [PAGE_BYTES-1:0] stage_mask;

  assign op        = eep_op_e'(cmd_op);
  assign accept    = cmd_valid && !busy_w;
  assign page      = page_of(cmd_addr);
  assign page_idx  = page[PW-1:0];
  assign ofs       = ofs_of(cmd_addr);
  assign in_range  = page_in_range(page, PAGES);
  assign load_go   = accept && (op == OP_LOAD);
  assign read_go   = accept && (op == OP_READ) && in_range;
  assign prog_go   = accept && (op == OP_PROG) && in_range;
  assign reject_go = accept && ((op == OP_READ) || (op == OP_PROG)) && !in_range;

  eep_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_go),
    .load_ofs (ofs),
    .load_data(cmd_wdata),
    .clear    (commit),
    .stage_q  (stage_q),
    .mask_q   (stage_mask)
  );

  eep_seq #(.PROG_CYCLES(PROG_CYCLES), .PW(PW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (prog_go),
    .start_page(page_idx),
    .busy      (busy_w),
    .commit    (commit),
    .done      (done_w),
    .tgt_page  (tgt_page)
  );

  eep_array #(.PAGES(PAGES), .PW(PW)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit),
    .tgt_page(tgt_page),
    .stage   (stage_q),
    .mask    (stage_mask),
    .rd_en   (read_go),
    .rd_page (page_idx),
    .rd_ofs  (ofs),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= reject_go;
  end

  assign busy = busy_w;
  assign done = done_w;

endmodule

// File: rtl/eep_ctrl_chk.sv
module eep_ctrl_chk
  import eep_pkg::*;
#(
  parameter int PAGES       = 32,
  parameter int PROG_CYCLES = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic [1:0]            cmd_op,
  input logic [11:0]           cmd_addr,
  input logic                  busy,
  input logic                  done,
  input logic                  err,
  input logic                  rd_valid,
  input logic [PAGE_BYTES-1:0] stage_mask,
  input logic                  commit
);

  logic good_page;
  int   run_len;

  assign good_page = 32'(cmd_addr[11:6]) < PAGES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!busy && !done && !err && !rd_valid && stage_mask == '0));

  assert_load_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && eep_op_e'(cmd_op) == OP_LOAD)
      |=> stage_mask[$past(cmd_addr[5:0])]);

  assert_read_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && eep_op_e'(cmd_op) == OP_READ && good_page) |=> rd_valid);

  assert_rdvalid_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && !busy && eep_op_e'(cmd_op) == OP_READ));

  assert_mask_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (stage_mask == '0));

  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && eep_op_e'(cmd_op) == OP_PROG && good_page) |=> busy);

  assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

  assert_commit_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> done);

  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == PROG_CYCLES));

  assert_stage_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(stage_mask));

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !rd_valid));

endmodule

bind eep_ctrl eep_ctrl_chk #(.PAGES(PAGES), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_addr  (cmd_addr),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .rd_valid  (rd_valid),
  .stage_mask(stage_mask),
  .commit    (commit)
);

// File: tb/sim_eep_ctrl.sv
`timescale 1ns/1ps
module sim_eep_ctrl;

  localparam int PAGES = 32;
  localparam int PROG  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [11:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        busy, done, err, rd_valid;
  logic [7:0]  rd_data;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  eep_ctrl #(.PAGES(PAGES), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .err(err), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Behavioural reference model
  int m_mem [PAGES*64];
  int m_stage [64];
  bit m_mask [64];
  int m_cnt = 0;
  int m_tgt = 0;
  bit m_done = 0, m_err = 0, m_rv = 0, m_live = 0;
  int m_rd = 0;
  int m_pg, m_of;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_err = 0; m_rv = 0; m_live = 0;
      for (int i = 0; i < 64; i++) begin m_stage[i] = 0; m_mask[i] = 0; end
    end else begin
      m_live = 1; m_done = 0; m_err = 0; m_rv = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          for (int i = 0; i < 64; i++) begin
            if (m_mask[i]) m_mem[m_tgt*64+i] = m_stage[i];
            m_mask[i] = 0;
          end
          m_done = 1;
        end
      end else if (cmd_valid) begin
        m_pg = int'(cmd_addr) / 64;
        m_of = int'(cmd_addr) % 64;
        case (cmd_op)
          2'b01: begin m_stage[m_of] = int'(cmd_wdata); m_mask[m_of] = 1; end
          2'b10: if (m_pg < PAGES) begin m_rv = 1; m_rd = m_mem[m_pg*64+m_of]; end
                 else m_err = 1;
          2'b11: if (m_pg < PAGES) begin m_cnt = PROG; m_tgt = m_pg; end
                 else m_err = 1;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && m_live && !finished) begin
      chk("R6 busy vs model", 32'(busy), 32'(m_cnt > 0));
      chk("R6 done vs model", 32'(done), 32'(m_done));
      chk("R8 err vs model", 32'(err), 32'(m_err));
      chk("R3 rd_valid vs model", 32'(rd_valid), 32'(m_rv));
      if (m_rv) chk("R3 rd_data vs model", 32'(rd_data), 32'(m_rd));
    end
  end

  function automatic logic [7:0] pat(int p, int o);
    return 8'((p * 37 + o * 11 + 3) & 255);
  endfunction

  task automatic cmd(logic [1:0] op, int addr, int wd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = 12'(addr); cmd_wdata = 8'(wd);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rd(int p, int o, output logic [7:0] d, output logic v);
    cmd(2'b10, p * 64 + o, 0);
    d = rd_data; v = rd_valid;
  endtask

  task automatic prog(int addr);
    cmd(2'b11, addr, 0);
    wait_idle();
  endtask

  task automatic expect_byte(string tag, int p, int o, logic [7:0] exp);
    logic [7:0] d; logic v;
    rd(p, o, d, v);
    chk(tag, 32'(v), 32'd1);
    chk(tag, 32'(d), 32'(exp));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    chk("R1 busy in reset", 32'(busy), 0);
    chk("R1 done in reset", 32'(done), 0);
    chk("R1 err in reset", 32'(err), 0);
    chk("R1 rd_valid in reset", 32'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Preload every page through full-page loads and commits
    for (int p = 0; p < PAGES; p++) begin
      for (int o = 0; o < 64; o++) cmd(2'b01, o, int'(pat(p, o)));
      prog(p * 64);
    end

    // R3: reads across the array
    expect_byte("R3 read p0 o0", 0, 0, pat(0, 0));
    expect_byte("R3 read p31 o63", 31, 63, pat(31, 63));
    expect_byte("R3 read p17 o22", 17, 22, pat(17, 22));

    // R2: load ignores page bits and leaves the array alone
    cmd(2'b01, 12'hFC5, 8'hA5);
    expect_byte("R2 array untouched by load", 3, 5, pat(3, 5));
    cmd(2'b01, 20 * 64 + 9, 8'h11);
    cmd(2'b01, 20 * 64 + 9, 8'h22);

    // R4 and R6: commit ignores low bits; busy length and done pulse
    cmd(2'b11, 3 * 64 + 42, 0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R6 busy cycles", 32'(n), 32'(PROG));
    chk("R6 done at busy fall", 32'(done), 1);
    @(negedge clk);
    chk("R6 done one cycle", 32'(done), 0);
    expect_byte("R4 staged byte 5", 3, 5, 8'hA5);
    expect_byte("R2 last load wins byte 9", 3, 9, 8'h22);
    expect_byte("R4 unstaged byte 4 kept", 3, 4, pat(3, 4));
    expect_byte("R4 low addr bits ignored byte 42", 3, 42, pat(3, 42));
    expect_byte("R2 page bits ignored p20", 20, 9, pat(20, 9));

    // R5: mask cleared, second commit changes nothing
    prog(4 * 64);
    expect_byte("R5 empty commit p4 o5", 4, 5, pat(4, 5));
    expect_byte("R5 empty commit p4 o9", 4, 9, pat(4, 9));

    // R7: commands dropped while busy
    cmd(2'b11, 6 * 64, 0);
    cmd(2'b01, 12, 8'h77);
    cmd(2'b10, 6 * 64 + 1, 0);
    chk("R7 read refused while busy", 32'(rd_valid), 0);
    wait_idle();
    // R7: load at the very edge the commit lands
    cmd(2'b11, 6 * 64, 0);
    repeat (PROG - 2) @(negedge clk);
    cmd(2'b01, 13, 8'h99);
    wait_idle();
    prog(7 * 64);
    expect_byte("R7 busy load dropped o12", 7, 12, pat(7, 12));
    expect_byte("R7 commit-edge load dropped o13", 7, 13, pat(7, 13));

    // R8: out-of-range page
    cmd(2'b10, 40 * 64 + 3, 0);
    chk("R8 read err", 32'(err), 1);
    chk("R8 read no rd_valid", 32'(rd_valid), 0);
    cmd(2'b01, 30, 8'h5A);
    cmd(2'b11, 32 * 64, 0);
    chk("R8 commit err", 32'(err), 1);
    chk("R8 commit no busy", 32'(busy), 0);
    prog(9 * 64);
    expect_byte("R8 staged byte kept", 9, 30, 8'h5A);
    expect_byte("R8 neighbour intact", 9, 31, pat(9, 31));

    // R9 and R1: persistence across reset, mask empty after reset
    cmd(2'b01, 0, 8'hEE);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_byte("R9 persist p3 o5", 3, 5, 8'hA5);
    expect_byte("R9 persist p9 o30", 9, 30, 8'h5A);
    expect_byte("R9 persist p17 o22", 17, 22, pat(17, 22));
    prog(2 * 64);
    expect_byte("R1 mask empty after reset", 2, 0, pat(2, 0));

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule